// File: doc/BRIEF.md
# Buffer Descriptor Stream Position Engine

This block moves the data of one audio stream through a list of memory buffers, one 32-bit word at a time. Software loads a table of buffer descriptors (base address, byte length, completion-flag request), writes the index of the last valid entry, and sets the run bit with a stream tag. The codec data path then asks for words with a request carrying a tag and a direction. The engine grants a word only when both match this stream. For each granted word it presents the memory address, and it advances its offset within the current buffer and the stream's link position.

When a buffer is used up exactly, the walk moves to the next descriptor. After the last valid descriptor it returns to entry 0 and the link position returns to 0. Zero-length entries are stepped over without a transfer. Finishing a buffer whose descriptor asks for it sets a sticky completion flag in the status byte. Every position change is also kept in a mirror register and, when enabled, written to this stream's 8-byte slot of a position area in memory. A stream-reset control clears the stream and leaves it with FIFO-ready and reset set.

The register window is relative to the stream. Offset 0x00 holds control in bits 23:0 and status in bits 31:24. Offset 0x04 holds the link position, read-only. Offset 0x0C holds the last valid index in bits 7:0. Offset 0x10 holds the position-area base, with the enable in bit 0 and the address in bits 31:3. Offset 0x2004 reads the mirrored position.

Top module: `bdse_stream_engine`

## Requirements
- R1: Each granted transfer moves one 4-byte word. `xfer_addr` equals the current descriptor base plus the in-buffer offset. Offset and link position (offset 0x04) both grow by 4.
- R2: When the offset after a transfer equals the descriptor length, the offset returns to 0 and the next descriptor becomes current. While the stream runs, a descriptor of length 0 is passed over in one cycle with no grant.
- R3: When the descriptor at the last valid index (offset 0x0C, bits 7:0) finishes, the index returns to 0 and the link position becomes 0.
- R4: Finishing a descriptor whose completion request is set sets status bit 2 (word bit 26 at offset 0x00). Writing 1 to that bit with byte lane 3 clears it.
- R5: The stream tag is control bits 23:20 and is captured when run rises. A request is granted only if `xfer_tag` equals the captured tag and `xfer_dir` equals the stream direction. The direction is 1 (output) when STREAM_IDX >= NUM_IN and 0 (input) otherwise.
- R6: Register writes honour byte enables. A write with only lane 2 enabled changes control bits 23:16 and leaves run and the other control bits as they were.
- R7: Writing control bit 0 as 1 (lane 0) resets the stream. Control reads back 0x000001, status 0x20 (FIFO-ready, bit 5), last valid index 0, position 0, and run is cleared.
- R8: A 0-to-1 change of run (control bit 1) sets position, offset and index to 0 and starts the walk. While run is 0 no request is granted.
- R9: Offset 0x2004 reads the same value as the link position at offset 0x04.
- R10: When position-area enable is set, each position change produces a one-cycle `pbuf_wr` in the next cycle. It carries the new position, at address base + 8*STREAM_IDX.
- R11: After reset all registers read 0, no request is granted and `pbuf_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 14 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte lane enables for the write |
| rd_addr | input | 14 | Register read offset |
| rd_data | output | 32 | Register read data, combinational |
| desc_wr | input | 1 | Descriptor table write strobe |
| desc_idx | input | IDX_W | Descriptor table entry written |
| desc_base | input | ADDR_W | Buffer base address for that entry |
| desc_len | input | LEN_W | Buffer length in bytes, a multiple of 4 |
| desc_ioc | input | 1 | Completion-flag request for that entry |
| xfer_req | input | 1 | Codec asks for one word |
| xfer_tag | input | 4 | Stream tag of the request |
| xfer_dir | input | 1 | Direction of the request, 1 for output |
| xfer_ack | output | 1 | Word granted this cycle |
| xfer_addr | output | ADDR_W | Memory address of the granted word |
| pbuf_wr | output | 1 | Position-area write strobe |
| pbuf_addr | output | 32 | Position-area write address |
| pbuf_data | output | 32 | Position value written |

## Verification
A fixed four-entry list is walked for ten words. The list mixes a flagged two-word buffer, an empty entry, an unflagged three-word buffer and a flagged one-word last buffer. This separates advancing on exact length, skipping empty entries, wrapping with position reset, and setting the completion flag only on flagged buffers. Requests with a wrong tag and with a wrong direction show that matching uses both fields. A lane-2 write between runs, followed by a restart, shows that the tag is captured at the run edge and that the walk restarts at entry 0. Stream reset is checked through the register values it leaves behind.

// File: rtl/bdse_pkg.sv
package bdse_pkg;
   localparam int REG_AW = 14;
   localparam logic [REG_AW-1:0] OFF_CTL   = 14'h0000;
   localparam logic [REG_AW-1:0] OFF_POS   = 14'h0004;
   localparam logic [REG_AW-1:0] OFF_LVI   = 14'h000C;
   localparam logic [REG_AW-1:0] OFF_PBUF  = 14'h0010;
   localparam logic [REG_AW-1:0] OFF_ALIAS = 14'h2004;
   localparam int CTL_SRST   = 0;
   localparam int CTL_RUN    = 1;
   localparam int TAG_LO     = 20;
   localparam int STS_DONE   = 2;
   localparam int STS_FRDY   = 5;
   localparam logic [7:0] STS_W1C = 8'h04;
   localparam int WORD_BYTES = 4;
   localparam int SLOT_BYTES = 8;
endpackage

// File: rtl/bdse_regs.sv
module bdse_regs
   import bdse_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [3:0]        wr_be,
   input  logic              done_set,
   output logic              run,
   output logic [3:0]        run_tag,
   output logic [7:0]        lvi,
   output logic [31:0]       pbuf_base,
   output logic              pbuf_en,
   output logic              start,
   output logic              srst,
   output logic [23:0]       ctl,
   output logic [7:0]        sts
);
   logic [23:0] ctl_q, ctl_merge;
   logic [7:0]  sts_q, sts_clr, lvi_q;
   logic [31:0] pbuf_q;
   logic [3:0]  tag_q;
   logic        hit_ctl;

   assign hit_ctl = wr_en && (wr_addr == OFF_CTL);

   for (genvar b = 0; b < 3; b++) begin : g_lane
      assign ctl_merge[8*b +: 8] = (hit_ctl && wr_be[b]) ? wr_data[8*b +: 8] : ctl_q[8*b +: 8];
   end

   assign srst    = hit_ctl && wr_be[0] && wr_data[CTL_SRST];
   assign start   = hit_ctl && !srst && !ctl_q[CTL_RUN] && ctl_merge[CTL_RUN];
   assign sts_clr = (hit_ctl && wr_be[3]) ? (wr_data[31:24] & STS_W1C) : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         sts_q  <= '0;
         lvi_q  <= '0;
         pbuf_q <= '0;
         tag_q  <= '0;
      end else begin
         if (srst) begin
            ctl_q <= 24'h000001;
            sts_q <= 8'(1 << STS_FRDY);
            lvi_q <= '0;
         end else begin
            ctl_q <= ctl_merge;
            sts_q <= (sts_q & ~sts_clr) | (done_set ? 8'(1 << STS_DONE) : 8'h00);
            if (wr_en && (wr_addr == OFF_LVI) && wr_be[0])
               lvi_q <= wr_data[7:0];
         end
         if (start)
            tag_q <= ctl_merge[TAG_LO +: 4];
         for (int b = 0; b < 4; b++)
            if (wr_en && (wr_addr == OFF_PBUF) && wr_be[b])
               pbuf_q[8*b +: 8] <= wr_data[8*b +: 8];
      end
   end

   assign run       = ctl_q[CTL_RUN];
   assign run_tag   = tag_q;
   assign lvi       = lvi_q;
   assign pbuf_base = {pbuf_q[31:3], 3'b000};
   assign pbuf_en   = pbuf_q[0];
   assign ctl       = ctl_q;
   assign sts       = sts_q;
endmodule

// File: rtl/bdse_desc_store.sv
module bdse_desc_store #(
   parameter int DEPTH  = 256,
   parameter int IDX_W  = 8,
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 32
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic              wr_ioc,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_base,
   output logic [LEN_W-1:0]  rd_len,
   output logic              rd_ioc
);
   logic [ADDR_W-1:0] base_mem [DEPTH];
   logic [LEN_W-1:0]  len_mem  [DEPTH];
   logic              ioc_mem  [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && (32'(wr_idx) < DEPTH)) begin
         base_mem[wr_idx] <= wr_base;
         len_mem[wr_idx]  <= wr_len;
         ioc_mem[wr_idx]  <= wr_ioc;
      end
   end

   if (DEPTH == (1 << IDX_W)) begin : g_full
      assign rd_base = base_mem[rd_idx];
      assign rd_len  = len_mem[rd_idx];
      assign rd_ioc  = ioc_mem[rd_idx];
   end else begin : g_guard
      logic in_range;
      assign in_range = 32'(rd_idx) < DEPTH;
      assign rd_base  = in_range ? base_mem[rd_idx] : '0;
      assign rd_len   = in_range ? len_mem[rd_idx]  : '0;
      assign rd_ioc   = in_range ? ioc_mem[rd_idx]  : 1'b0;
   end
endmodule

// File: rtl/bdse_walker.sv
module bdse_walker
   import bdse_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 32,
   parameter int IDX_W   = 8,
   parameter bit DIR_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              start,
   input  logic              srst,
   input  logic [3:0]        run_tag,
   input  logic [7:0]        lvi,
   input  logic [ADDR_W-1:0] d_base,
   input  logic [LEN_W-1:0]  d_len,
   input  logic              d_ioc,
   input  logic              xfer_req,
   input  logic [3:0]        xfer_tag,
   input  logic              xfer_dir,
   output logic [IDX_W-1:0]  idx,
   output logic              xfer_ack,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic              done_set,
   output logic              pos_upd,
   output logic [31:0]       pos_d,
   output logic [31:0]       pos
);
   logic [LEN_W-1:0] off_q, off_d, off_inc;
   logic [IDX_W-1:0] idx_q, idx_d, idx_adv;
   logic [31:0]      pos_q;
   logic             empty, match, fin, last, skip;

   assign empty     = (d_len == '0);
   assign match     = (xfer_tag == run_tag) && (xfer_dir == DIR_OUT);
   assign xfer_ack  = run && !empty && xfer_req && match;
   assign skip      = run && empty;
   assign off_inc   = off_q + LEN_W'(WORD_BYTES);
   assign fin       = (off_inc == d_len);
   assign last      = (8'(idx_q) == lvi);
   assign idx_adv   = last ? '0 : idx_q + 1'b1;
   assign xfer_addr = d_base + ADDR_W'(off_q);
   assign done_set  = xfer_ack && fin && d_ioc;

   always_comb begin
      off_d = off_q;
      idx_d = idx_q;
      pos_d = pos_q;
      if (start || srst) begin
         off_d = '0;
         idx_d = '0;
         pos_d = '0;
      end else if (xfer_ack) begin
         pos_d = pos_q + 32'(WORD_BYTES);
         off_d = off_inc;
         if (fin) begin
            off_d = '0;
            idx_d = idx_adv;
            if (last) pos_d = '0;
         end
      end else if (skip) begin
         off_d = '0;
         idx_d = idx_adv;
         if (last) pos_d = '0;
      end
   end

   assign pos_upd = start || (pos_d != pos_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= '0;
         idx_q <= '0;
         pos_q <= '0;
      end else begin
         off_q <= off_d;
         idx_q <= idx_d;
         pos_q <= pos_d;
      end
   end

   assign idx = idx_q;
   assign pos = pos_q;
endmodule

// File: rtl/bdse_pos_mirror.sv
module bdse_pos_mirror #(
   parameter int SLOT_OFF = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] pos_d,
   input  logic        upd,
   input  logic        pbuf_en,
   input  logic [31:0] pbuf_base,
   output logic [31:0] alias_pos,
   output logic        pbuf_wr,
   output logic [31:0] pbuf_addr,
   output logic [31:0] pbuf_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alias_pos <= '0;
         pbuf_wr   <= 1'b0;
         pbuf_addr <= '0;
         pbuf_data <= '0;
      end else begin
         alias_pos <= pos_d;
         pbuf_wr   <= upd && pbuf_en;
         if (upd) begin
            pbuf_data <= pos_d;
            pbuf_addr <= pbuf_base + 32'(SLOT_OFF);
         end
      end
   end
endmodule

// File: rtl/bdse_stream_engine.sv
module bdse_stream_engine
   import bdse_pkg::*;
#(
   parameter int MAX_DESC    = 256,
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 32,
   parameter int NUM_IN      = 4,
   parameter int NUM_STREAMS = 8,
   parameter int STREAM_IDX  = 4,
   localparam int IDX_W      = $clog2(MAX_DESC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [13:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic [3:0]        reg_be,
   input  logic [13:0]       rd_addr,
   output logic [31:0]       rd_data,
   input  logic              desc_wr,
   input  logic [IDX_W-1:0]  desc_idx,
   input  logic [ADDR_W-1:0] desc_base,
   input  logic [LEN_W-1:0]  desc_len,
   input  logic              desc_ioc,
   input  logic              xfer_req,
   input  logic [3:0]        xfer_tag,
   input  logic              xfer_dir,
   output logic              xfer_ack,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic              pbuf_wr,
   output logic [31:0]       pbuf_addr,
   output logic [31:0]       pbuf_data
);
   localparam bit DIR_OUT  = (STREAM_IDX >= NUM_IN);
   localparam int SLOT_OFF = STREAM_IDX * SLOT_BYTES;

   if (MAX_DESC < 2 || MAX_DESC > 256) begin : g_bad_depth
      $error("MAX_DESC must lie in 2..256");
   end
   if (STREAM_IDX >= NUM_STREAMS || NUM_IN > NUM_STREAMS) begin : g_bad_idx
      $error("stream index or input count out of range");
   end
   if (LEN_W > 32 || LEN_W < 3) begin : g_bad_len
      $error("LEN_W must lie in 3..32");
   end

   logic              run_w, start_w, srst_w, pbuf_en_w, done_w, upd_w;
   logic [3:0]        tag_w;
   logic [7:0]        lvi_w, sts_w;
   logic [23:0]       ctl_w;
   logic [31:0]       pbuf_base_w, pos_w, pos_d_w, alias_w;
   logic [IDX_W-1:0]  idx_w;
   logic [ADDR_W-1:0] cur_base;
   logic [LEN_W-1:0]  cur_len;
   logic              cur_ioc;

   bdse_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
      .wr_data(reg_wdata), .wr_be(reg_be), .done_set(done_w),
      .run(run_w), .run_tag(tag_w), .lvi(lvi_w), .pbuf_base(pbuf_base_w),
      .pbuf_en(pbuf_en_w), .start(start_w), .srst(srst_w), .ctl(ctl_w), .sts(sts_w)
   );

   bdse_desc_store #(.DEPTH(MAX_DESC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_store (
      .clk(clk), .wr_en(desc_wr), .wr_idx(desc_idx), .wr_base(desc_base),
      .wr_len(desc_len), .wr_ioc(desc_ioc), .rd_idx(idx_w),
      .rd_base(cur_base), .rd_len(cur_len), .rd_ioc(cur_ioc)
   );

   bdse_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .DIR_OUT(DIR_OUT)) u_walk (
      .clk(clk), .rst_n(rst_n), .run(run_w), .start(start_w), .srst(srst_w),
      .run_tag(tag_w), .lvi(lvi_w), .d_base(cur_base), .d_len(cur_len), .d_ioc(cur_ioc),
      .xfer_req(xfer_req), .xfer_tag(xfer_tag), .xfer_dir(xfer_dir),
      .idx(idx_w), .xfer_ack(xfer_ack), .xfer_addr(xfer_addr), .done_set(done_w),
      .pos_upd(upd_w), .pos_d(pos_d_w), .pos(pos_w)
   );

   bdse_pos_mirror #(.SLOT_OFF(SLOT_OFF)) u_mirror (
      .clk(clk), .rst_n(rst_n), .pos_d(pos_d_w), .upd(upd_w), .pbuf_en(pbuf_en_w),
      .pbuf_base(pbuf_base_w), .alias_pos(alias_w), .pbuf_wr(pbuf_wr),
      .pbuf_addr(pbuf_addr), .pbuf_data(pbuf_data)
   );

   always_comb begin
      case (rd_addr)
         OFF_CTL:   rd_data = {sts_w, ctl_w};
         OFF_POS:   rd_data = pos_w;
         OFF_LVI:   rd_data = {24'h0, lvi_w};
         OFF_PBUF:  rd_data = {pbuf_base_w[31:3], 2'b00, pbuf_en_w};
         OFF_ALIAS: rd_data = alias_w;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/bdse_checker.sv
module bdse_checker
   import bdse_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        run,
   input logic        xfer_ack,
   input logic [3:0]  xfer_tag,
   input logic [3:0]  run_tag,
   input logic [31:0] pos,
   input logic [31:0] alias_pos,
   input logic        pbuf_en,
   input logic        pbuf_wr,
   input logic        srst,
   input logic        done_set,
   input logic [7:0]  sts
);
   assert_word_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack |=> (pos == $past(pos) + 32'd4) || (pos == 32'd0));

   assert_pos_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pos[1:0] == 2'b00);

   assert_done_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_set && !srst) |=> sts[STS_DONE]);

   assert_tag_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack |-> (xfer_tag == run_tag));

   assert_srst_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (sts[STS_FRDY] && !run));

   assert_no_grant_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !xfer_ack);

   assert_alias_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      alias_pos == pos);

   assert_pbuf_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ack && pbuf_en) |=> pbuf_wr);
endmodule

bind bdse_stream_engine bdse_checker u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_w), .xfer_ack(xfer_ack), .xfer_tag(xfer_tag),
   .run_tag(tag_w), .pos(pos_w), .alias_pos(alias_w), .pbuf_en(pbuf_en_w),
   .pbuf_wr(pbuf_wr), .srst(srst_w), .done_set(done_w), .sts(sts_w)
);

// File: tb/sim_bdse_stream_engine.sv
module sim_bdse_stream_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [13:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  reg_be = '0;
   logic [13:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic        desc_wr = 1'b0;
   logic [7:0]  desc_idx = '0;
   logic [31:0] desc_base = '0;
   logic [31:0] desc_len = '0;
   logic        desc_ioc = 1'b0;
   logic        xfer_req = 1'b0;
   logic [3:0]  xfer_tag = '0;
   logic        xfer_dir = 1'b0;
   logic        xfer_ack;
   logic [31:0] xfer_addr;
   logic        pbuf_wr;
   logic [31:0] pbuf_addr, pbuf_data;

   int checks = 0;
   int fails = 0;

   always #4 clk = ~clk;

   bdse_stream_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_be(reg_be), .rd_addr(rd_addr), .rd_data(rd_data), .desc_wr(desc_wr),
      .desc_idx(desc_idx), .desc_base(desc_base), .desc_len(desc_len), .desc_ioc(desc_ioc),
      .xfer_req(xfer_req), .xfer_tag(xfer_tag), .xfer_dir(xfer_dir), .xfer_ack(xfer_ack),
      .xfer_addr(xfer_addr), .pbuf_wr(pbuf_wr), .pbuf_addr(pbuf_addr), .pbuf_data(pbuf_data)
   );

   // walk vectors: [63:32] expected word address, [31:8] expected position, [7:0] completion flag
   localparam logic [63:0] VEC [10] = '{
      64'h00001000_00000400, 64'h00001004_00000801, 64'h00003000_00000C00,
      64'h00003004_00001000, 64'h00003008_00001400, 64'h00004000_00000001,
      64'h00001000_00000400, 64'h00001004_00000801, 64'h00003000_00000C00,
      64'h00003004_00001000
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [13:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = '0;
   endtask

   task automatic rd(input logic [13:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic load(input int i, input logic [31:0] b, input logic [31:0] l, input logic c);
      @(negedge clk);
      desc_wr = 1'b1; desc_idx = 8'(i); desc_base = b; desc_len = l; desc_ioc = c;
      @(negedge clk);
      desc_wr = 1'b0;
   endtask

   task automatic xfer(input logic [3:0] tg, input logic dr, output logic [31:0] a, output logic ok);
      ok = 1'b0; a = '0;
      @(negedge clk);
      xfer_req = 1'b1; xfer_tag = tg; xfer_dir = dr;
      for (int k = 0; k < 20 && !ok; k++) begin
         #1;
         if (xfer_ack) begin ok = 1'b1; a = xfer_addr; end
         else @(negedge clk);
      end
      @(negedge clk);
      xfer_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d, a;
      logic ok;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      @(negedge clk);
      xfer_req = 1'b1; xfer_tag = 4'h0; xfer_dir = 1'b1;
      #1;
      chk("R11 no grant after reset", 32'(xfer_ack), 32'd0);
      chk("R11 pbuf_wr low", 32'(pbuf_wr), 32'd0);
      rd(14'h000, d); chk("R11 control/status", d, 32'h0);
      rd(14'h004, d); chk("R11 position", d, 32'h0);
      rd(14'h2004, d); chk("R11 alias", d, 32'h0);
      xfer_req = 1'b0;

      load(0, 32'h1000, 32'd8, 1'b1);
      load(1, 32'h2000, 32'd0, 1'b1);
      load(2, 32'h3000, 32'd12, 1'b0);
      load(3, 32'h4000, 32'd4, 1'b1);
      wr(14'h00C, 32'd3, 4'b0001);
      wr(14'h010, 32'h0000_8001, 4'b1111);

      // R8 start: position write of zero to slot 4*8
      wr(14'h000, 32'h0050_0002, 4'b1111);
      chk("R10 start pbuf_wr", 32'(pbuf_wr), 32'd1);
      chk("R8 start pbuf data", pbuf_data, 32'h0);
      chk("R10 pbuf address", pbuf_addr, 32'h8020);

      for (int i = 0; i < 10; i++) begin
         xfer(4'h5, 1'b1, a, ok);
         chk("R2 grant", 32'(ok), 32'd1);
         chk("R1 R2 word address", a, VEC[i][63:32]);
         chk("R10 pbuf_wr", 32'(pbuf_wr), 32'd1);
         chk("R10 pbuf data", pbuf_data, {8'h0, VEC[i][31:8]});
         rd(14'h004, d); chk("R1 R3 position", d, {8'h0, VEC[i][31:8]});
         rd(14'h2004, d); chk("R9 alias", d, {8'h0, VEC[i][31:8]});
         rd(14'h000, d); chk("R4 completion bit", 32'(d[26]), 32'(VEC[i][0]));
         if (VEC[i][0]) begin
            wr(14'h000, 32'h0400_0000, 4'b1000);
            rd(14'h000, d); chk("R4 completion cleared", 32'(d[26]), 32'd0);
         end
      end

      // R5 wrong tag, then wrong direction
      @(negedge clk);
      xfer_req = 1'b1; xfer_tag = 4'h6; xfer_dir = 1'b1;
      #1; chk("R5 wrong tag refused", 32'(xfer_ack), 32'd0);
      xfer_tag = 4'h5; xfer_dir = 1'b0;
      #1; chk("R5 wrong direction refused", 32'(xfer_ack), 32'd0);
      @(negedge clk);
      xfer_req = 1'b0;
      rd(14'h004, d); chk("R5 position untouched", d, 32'd16);

      // R6 lane-2 write changes tag field only
      wr(14'h000, 32'h00A0_0000, 4'b0100);
      rd(14'h000, d); chk("R6 lane 2 write", d, 32'h00A0_0002);

      // R8 stop
      wr(14'h000, 32'h0000_0000, 4'b0001);
      @(negedge clk);
      xfer_req = 1'b1; xfer_tag = 4'h5; xfer_dir = 1'b1;
      #1; chk("R8 no grant when stopped", 32'(xfer_ack), 32'd0);
      @(negedge clk);
      xfer_req = 1'b0;
      rd(14'h004, d); chk("R8 position held when stopped", d, 32'd16);

      // R8 restart picks up new tag and resets walk
      wr(14'h000, 32'h0000_0002, 4'b0001);
      chk("R8 restart pbuf data", pbuf_data, 32'h0);
      rd(14'h004, d); chk("R8 restart position", d, 32'h0);
      xfer(4'hA, 1'b1, a, ok);
      chk("R5 new tag granted", 32'(ok), 32'd1);
      chk("R8 restart first address", a, 32'h1000);

      // R7 stream reset
      wr(14'h000, 32'h0000_0001, 4'b0001);
      rd(14'h000, d); chk("R7 control/status after reset", d, 32'h2000_0001);
      rd(14'h004, d); chk("R7 position after reset", d, 32'h0);
      rd(14'h00C, d); chk("R7 last index after reset", d, 32'h0);
      @(negedge clk);
      xfer_req = 1'b1; xfer_tag = 4'hA; xfer_dir = 1'b1;
      #1; chk("R7 no grant after stream reset", 32'(xfer_ack), 32'd0);
      xfer_req = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule